// File: doc/BRIEF.md
# Bulk-In Packet Release Controller

This block sits between a receive byte buffer and the endpoint logic that serves bulk-in requests from a host. On each request it decides whether to answer with data (ACK) or to refuse (NAK). If it answers with data, it also gives the number of bytes to move. A full packet of buffered bytes is always released at once. A partial packet is held back until the receive line has been quiet for longer than three character times. This keeps host traffic to full-size packets while data is streaming, and it still flushes the tail of a burst.

At slow line rates, waiting three character times adds too much latency. A low-latency mode therefore releases any nonzero buffered data on the next request. The mode switches on automatically when the configured bit period is long, and a configuration bit can also force it on. The block does not serialise packets, store the bytes or speak the bus protocol. It only watches the buffer occupancy, the character arrivals and the rate setting.

Top module: `bulkin_release_ctrl`

## Requirements
- R1: During and after synchronous reset, `ack_o` and `nak_o` are 0 and `xfer_cnt_o` is 0.
- R2: A request with `occ_i` >= PKT_BYTES (64) gives ACK, and `xfer_cnt_o` = 64.
- R3: A request with 0 < `occ_i` < 64 gives NAK when low-latency mode is off and the line is not idle.
- R4: The line is idle once more than IDLE_CHARS (3) character times have passed since the last `rx_char_i` pulse. One character time is `bit_div_i` * FRAME_BITS (10) clocks. A request with 0 < `occ_i` < 64 on an idle line gives ACK, and `xfer_cnt_o` = `occ_i`.
- R5: Each `rx_char_i` pulse restarts the idle measurement. A request that comes less than three character times after the most recent pulse gets NAK for a partial packet, however long ago earlier pulses came.
- R6: Low-latency mode is on automatically while `bit_div_i` > SLOW_DIV (1066 clocks per bit, which is a rate below about 46.9 kbit/s at 50 MHz). In this mode a request with 0 < `occ_i` < 64 gives ACK with `xfer_cnt_o` = `occ_i`, without waiting for idle.
- R7: Setting `lowlat_force_i` = 1 turns on low-latency mode at any `bit_div_i`, with the same release rule as R6.
- R8: A request with `occ_i` = 0 gives NAK in every mode and idle state.
- R9: `ack_o` or `nak_o` pulses high for exactly one cycle, in the cycle after the clock edge that samples `req_i`. Exactly one of them pulses for each request. Neither goes high without a request.
- R10: `xfer_cnt_o` is loaded only when ACK is issued. It keeps its value through NAKs and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_i | input | OCC_W (10) | Bytes currently buffered |
| rx_char_i | input | 1 | One-cycle pulse per received character |
| bit_div_i | input | DIV_W (16) | Clocks per serial bit |
| lowlat_force_i | input | 1 | Manual low-latency enable |
| req_i | input | 1 | Bulk-in request strobe |
| ack_o | output | 1 | Data-ready answer pulse |
| nak_o | output | 1 | Not-ready answer pulse |
| xfer_cnt_o | output | CNT_W (7) | Bytes to transfer, latched on ACK |

## Verification
The hardest case to reach is the idle boundary, because it depends on how much time has passed since the last character. That time is not visible at any port. The bench drives a small bit divisor so one character time is 20 clocks. It then times every request from its own character pulse, with gaps drawn at random but kept clear of the 60-clock threshold. This makes the expected idle state known exactly. Directed cases then add a second character partway through the window to check the restart, and switch between slow and fast divisors to cover the automatic low-latency mode.

// File: rtl/bulkin_release_pkg.sv
package bulkin_release_pkg;
  typedef enum logic [1:0] {
    REL_NAK  = 2'd0,
    REL_FULL = 2'd1,
    REL_PART = 2'd2
  } rel_kind_e;
endpackage

// File: rtl/char_clock.sv
module char_clock #(
  parameter int DIV_W      = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] bit_div_i,
  output logic             char_tick_o
);
  localparam int FB_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [DIV_W-1:0] bit_cnt;
  logic [FB_W-1:0]  frm_cnt;
  logic             bit_end;
  logic             frm_end;

  assign bit_end     = ({1'b0, bit_cnt} + 1'b1) >= {1'b0, bit_div_i};
  assign frm_end     = frm_cnt == FB_W'(FRAME_BITS - 1);
  assign char_tick_o = bit_end && frm_end && !restart_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      bit_cnt <= '0;
      frm_cnt <= '0;
    end else if (bit_end) begin
      bit_cnt <= '0;
      frm_cnt <= frm_end ? '0 : frm_cnt + 1'b1;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R5: a restart brings the phase back to zero
  a_r5_phase_restart: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (bit_cnt == '0 && frm_cnt == '0));
endmodule

// File: rtl/idle_tracker.sv
module idle_tracker #(
  parameter int IDLE_CHARS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic char_tick_i,
  output logic idle_o
);
  localparam int IC_W = $clog2(IDLE_CHARS + 1);

  logic [IC_W-1:0] chr_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart_i)
      chr_cnt <= '0;
    else if (char_tick_i && chr_cnt != IC_W'(IDLE_CHARS))
      chr_cnt <= chr_cnt + 1'b1;
  end

  assign idle_o = chr_cnt == IC_W'(IDLE_CHARS);

  // R5: a received character always ends the idle state
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !idle_o);
  // R4: idle can only be entered on a character tick
  a_r4_idle_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_o) |-> $past(char_tick_i));
endmodule

// File: rtl/release_decide.sv
module release_decide
  import bulkin_release_pkg::*;
#(
  parameter int OCC_W     = 10,
  parameter int PKT_BYTES = 64,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             idle_i,
  input  logic             lowlat_i,
  output logic             ack_o,
  output logic             nak_o,
  output logic [CNT_W-1:0] xfer_cnt_o
);
  rel_kind_e kind;

  always_comb begin
    if (occ_i == '0)
      kind = REL_NAK;
    else if (occ_i >= OCC_W'(PKT_BYTES))
      kind = REL_FULL;
    else if (lowlat_i || idle_i)
      kind = REL_PART;
    else
      kind = REL_NAK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o      <= 1'b0;
      nak_o      <= 1'b0;
      xfer_cnt_o <= '0;
    end else begin
      ack_o <= req_i && (kind != REL_NAK);
      nak_o <= req_i && (kind == REL_NAK);
      if (req_i && kind == REL_FULL)
        xfer_cnt_o <= CNT_W'(PKT_BYTES);
      else if (req_i && kind == REL_PART)
        xfer_cnt_o <= CNT_W'(occ_i);
    end
  end

  // R9: one answer per request, never both
  a_r9_one_answer: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (ack_o ^ nak_o));
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !(ack_o || nak_o));
  // R8: empty buffer is refused
  a_r8_empty_nak: assert property (@(posedge clk) disable iff (rst)
    (req_i && occ_i == '0) |=> nak_o);
  // R2: full packet
  a_r2_full_pkt: assert property (@(posedge clk) disable iff (rst)
    (req_i && occ_i >= OCC_W'(PKT_BYTES)) |=> (ack_o && xfer_cnt_o == CNT_W'(PKT_BYTES)));
  // R10: count holds unless an ACK was issued
  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> $stable(xfer_cnt_o));
  // R3: partial packet, not idle, not low-latency
  a_r3_partial_nak: assert property (@(posedge clk) disable iff (rst)
    (req_i && occ_i != '0 && occ_i < OCC_W'(PKT_BYTES) && !idle_i && !lowlat_i) |=> nak_o);
endmodule

// File: rtl/bulkin_release_ctrl.sv
module bulkin_release_ctrl #(
  parameter int OCC_W      = 10,
  parameter int DIV_W      = 16,
  parameter int PKT_BYTES  = 64,
  parameter int FRAME_BITS = 10,
  parameter int IDLE_CHARS = 3,
  parameter int SLOW_DIV   = 1066,
  localparam int CNT_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             rx_char_i,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic             lowlat_force_i,
  input  logic             req_i,
  output logic             ack_o,
  output logic             nak_o,
  output logic [CNT_W-1:0] xfer_cnt_o
);
  logic char_tick;
  logic idle;
  logic lowlat_q;

  always_ff @(posedge clk) begin
    if (rst)
      lowlat_q <= 1'b0;
    else
      lowlat_q <= lowlat_force_i || (bit_div_i > DIV_W'(SLOW_DIV));
  end

  char_clock #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_clk (
    .clk(clk), .rst(rst), .restart_i(rx_char_i),
    .bit_div_i(bit_div_i), .char_tick_o(char_tick)
  );

  idle_tracker #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk(clk), .rst(rst), .restart_i(rx_char_i),
    .char_tick_i(char_tick), .idle_o(idle)
  );

  release_decide #(.OCC_W(OCC_W), .PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .req_i(req_i), .occ_i(occ_i),
    .idle_i(idle), .lowlat_i(lowlat_q),
    .ack_o(ack_o), .nak_o(nak_o), .xfer_cnt_o(xfer_cnt_o)
  );

  // R6 and R7: low-latency releases partial data immediately
  a_r6_lowlat_release: assert property (@(posedge clk) disable iff (rst)
    (req_i && lowlat_q && occ_i != '0 && occ_i < OCC_W'(PKT_BYTES))
      |=> (ack_o && xfer_cnt_o == CNT_W'($past(occ_i))));
  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!ack_o && !nak_o && xfer_cnt_o == '0));
endmodule

// File: tb/bulkin_release_ctrl_test.sv
module bulkin_release_ctrl_test;
  localparam int PKT = 64;
  localparam int WIN = 2 * 10 * 3; // idle window at divisor 2

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] occ = '0;
  logic       rxc = 1'b0;
  logic [15:0] div = 16'd2;
  logic       force_ll = 1'b0;
  logic       req = 1'b0;
  logic       ack, nak;
  logic [6:0] cnt;

  int checks = 0;
  int errors = 0;
  int last_ack_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bulkin_release_ctrl uut (
    .clk(clk), .rst(rst), .occ_i(occ), .rx_char_i(rxc), .bit_div_i(div),
    .lowlat_force_i(force_ll), .req_i(req), .ack_o(ack), .nak_o(nak),
    .xfer_cnt_o(cnt)
  );

  function automatic bit exp_ack(int o, bit ll, bit idl);
    if (o == 0) return 1'b0;
    if (o >= PKT) return 1'b1;
    return ll || idl;
  endfunction

  function automatic int exp_cnt(int o);
    return (o >= PKT) ? PKT : o;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rx();
    rxc = 1'b1;
    @(negedge clk);
    rxc = 1'b0;
  endtask

  task automatic do_req(string tag, int o, bit ll, bit idl);
    bit ea;
    occ = o[9:0];
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    ea = exp_ack(o, ll, idl);
    check({tag, " ack"}, ack, ea);
    check({tag, " nak"}, nak, !ea);
    if (ea) last_ack_cnt = exp_cnt(o);
    check({tag, " cnt"}, cnt, last_ack_cnt);
    @(negedge clk);
    check({tag, " R9 single pulse"}, ack | nak, 0);
  endtask

  initial begin
    wait_cyc(3);
    check("R1 ack", ack, 0);
    check("R1 nak", nak, 0);
    check("R1 cnt", cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", ack | nak, 0);
    check("R1 cnt after release", cnt, 0);

    pulse_rx();
    wait_cyc(5);
    do_req("R2 full", 64, 0, 0);
    do_req("R2 over", 700, 0, 0);
    do_req("R3 partial busy", 17, 0, 0);
    do_req("R10 hold after nak", 5, 0, 0);
    do_req("R8 empty busy", 0, 0, 0);

    pulse_rx();
    wait_cyc(WIN + 10);
    do_req("R4 partial idle", 23, 0, 1);
    do_req("R8 empty idle", 0, 0, 1);
    do_req("R4 one byte idle", 1, 0, 1);

    pulse_rx();
    wait_cyc(40);
    pulse_rx();
    wait_cyc(40);
    do_req("R5 restart", 9, 0, 0);
    wait_cyc(WIN);
    do_req("R5 idle after restart", 9, 0, 1);

    pulse_rx();
    wait_cyc(WIN - 8);
    do_req("R4 just before window", 12, 0, 0);

    div = 16'd1067;
    pulse_rx();
    wait_cyc(3);
    do_req("R6 auto lowlat", 33, 1, 0);
    do_req("R8 empty lowlat", 0, 1, 0);
    div = 16'd1066;
    pulse_rx();
    wait_cyc(3);
    do_req("R6 at threshold", 33, 0, 0);

    force_ll = 1'b1;
    div = 16'd2;
    pulse_rx();
    wait_cyc(3);
    do_req("R7 manual lowlat", 63, 1, 0);
    do_req("R8 empty manual", 0, 1, 0);
    force_ll = 1'b0;

    req = 1'b0;
    wait_cyc(10);
    check("R9 idle no answer", ack | nak, 0);
    check("R10 cnt held", cnt, last_ack_cnt);

    void'($urandom(32'd1234));
    for (int it = 0; it < 200; it++) begin
      int o, gap, sel;
      bit ll, idl;
      sel = $urandom_range(0, 3);
      case (sel)
        0: o = 0;
        1: o = $urandom_range(1, 63);
        2: o = $urandom_range(64, 1023);
        default: o = $urandom_range(1, 80);
      endcase
      force_ll = ($urandom_range(0, 4) == 0);
      div = ($urandom_range(0, 4) == 0) ? 16'($urandom_range(1067, 4000)) : 16'd2;
      ll = force_ll || (div > 16'd1066);
      pulse_rx();
      if ($urandom_range(0, 1) == 1) gap = $urandom_range(3, WIN - 4);
      else gap = $urandom_range(WIN + 4, WIN + 40);
      wait_cyc(gap);
      idl = (div == 16'd2) && (gap > WIN);
      do_req(ll ? "R6 R7 random lowlat" : "R3 R4 R8 random", o, ll, idl);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule